// File: doc/BRIEF.md
# Periodic Split Transaction Pipeline

This block holds the periodic (isochronous and interrupt) work of a translator that sits between a high-speed upstream link and a full-/low-speed downstream bus. Upstream logic writes start-split records into the block. Each record holds an endpoint/address tag and an optional OUT payload word. The downstream full-/low-speed engine reads these records strictly in arrival order whenever its bus is free for the next periodic transaction. Results from the downstream side are placed in a second, separate queue. The upstream side later drains that queue by issuing complete-split lookups.

A lookup is compared against the entry at the head of the result queue. The possible outcomes are:
- **Hit:** the tag matches. The head entry's status and data are returned and the entry is removed.
- **Miss:** the tag does not match. A no-response code is returned and the queue is left untouched.
- **Underrun:** the queue is empty. An empty code is returned and the underrun flag is raised.

The lookup logic is a small state machine with four states:
- **CS_IDLE:** no response this cycle.
- **CS_HIT:** a hit is being returned.
- **CS_MISS:** a miss is being returned.
- **CS_UNDER:** an underrun is being returned.

Every cycle, the machine takes one of four transitions out of any state. With no request it goes to CS_IDLE. A request against an empty queue goes to CS_UNDER. A request whose tag equals the head tag goes to CS_HIT. Any other request goes to CS_MISS. Each response state therefore lasts exactly one cycle, unless a new request follows directly.

A microframe counter advances on each 125 µs tick and marks the start of every 1 ms downstream frame, which is made of eight microframes. If an IN packet is still arriving when a tick comes, the block records a "more data" result for that endpoint on its own.

Top module: `periodic_split_pipe`

## Requirements
- R1: After reset both queues are empty: `ss_ready` and `res_ready` are 1, while `dn_valid`, `cs_resp_valid`, `cs_udr` and `frame_start` are 0, and `uf_num` is 0.
- R2: Start-split records leave on the downstream port (`dn_valid`/`dn_ready`) in exactly the order they were accepted on `ss_valid`/`ss_ready`, with tag and data intact.
- R3: When the start-split queue holds SS_DEPTH records, `ss_ready` is 0, `ss_ovr` is 1 for every cycle in which `ss_valid` is 1, and the offered record is not stored.
- R4: A result accepted on `res_valid`/`res_ready` is appended to the complete-split queue with its tag, 3-bit status and data. The status codes are: ACK=0, NAK=1, STALL=2, transaction error=3, last data=4, more data=5, no response=6, empty=7.
- R5: A complete-split lookup whose tag equals the head tag produces, one cycle later, a one-cycle `cs_resp_valid` carrying the head's status and data, and the head entry is removed.
- R6: A lookup whose tag differs from the head tag answers one cycle later with status 6 and data 0, and leaves the queue unchanged.
- R7: A lookup against an empty result queue answers one cycle later with status 7 and data 0, and `cs_udr` is 1 in that response cycle.
- R8: When `uf_tick` and `rx_active` are both 1 and the result queue is not full, an entry with tag `rx_ep`, status 5 and data 0 is appended, and `res_ready` is 0 in that cycle.
- R9: `uf_num` increments on each `uf_tick` and wraps from UF_PER_FRAME-1 to 0. On the wrap, `frame_start` is 1 for exactly the following cycle.
- R10: The two queues have separate storage: a full start-split queue does not lower `res_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss_valid | input | 1 | Start-split record offered |
| ss_ready | output | 1 | Start-split queue has room |
| ss_ep | input | EP_W | Endpoint/address tag of the record |
| ss_data | input | DATA_W | OUT payload word of the record |
| ss_ovr | output | 1 | Overrun: record offered while the queue is full |
| dn_valid | output | 1 | Head start-split available downstream |
| dn_ready | input | 1 | Downstream bus free, takes the head record |
| dn_ep | output | EP_W | Head record tag |
| dn_data | output | DATA_W | Head record payload |
| res_valid | input | 1 | Downstream result offered |
| res_ready | output | 1 | Result accepted this cycle |
| res_ep | input | EP_W | Result tag |
| res_status | input | 3 | Result status code |
| res_data | input | DATA_W | Result data word |
| rx_active | input | 1 | An IN data packet is being received |
| rx_ep | input | EP_W | Tag of the packet being received |
| uf_tick | input | 1 | Microframe boundary pulse |
| uf_num | output | $clog2(UF_PER_FRAME) | Current microframe number |
| frame_start | output | 1 | One-cycle pulse after a frame wrap |
| cs_valid | input | 1 | Complete-split lookup |
| cs_ready | output | 1 | Lookup accepted (always 1) |
| cs_ep | input | EP_W | Lookup tag |
| cs_resp_valid | output | 1 | Lookup response valid |
| cs_resp_status | output | 3 | Response status code |
| cs_resp_data | output | DATA_W | Response data word |
| cs_udr | output | 1 | Underrun: lookup found the result queue empty |

## Verification
Several rules are checked by the assertions on every cycle:
- neither circular buffer is written while full or read while empty;
- a tag mismatch never removes the head entry, and a match always does;
- a microframe-boundary capture always blocks the result port in that cycle;
- `frame_start` only appears together with microframe 0;
- the underrun flag and the empty code always appear together.

Other behaviour can only be shown by the bench's scenarios:
- records leave in arrival order with their contents intact;
- a rejected overrun record never appears downstream;
- a miss leaves the same head entry to be matched later;
- a "more data" entry carries the right tag;
- the counter wraps after exactly eight ticks.

// File: rtl/psp_pkg.sv
package psp_pkg;

    // Status codes carried by complete-split results and responses
    typedef enum logic [2:0] {
        RSP_ACK   = 3'd0,
        RSP_NAK   = 3'd1,
        RSP_STALL = 3'd2,
        RSP_TERR  = 3'd3,
        RSP_LAST  = 3'd4,
        RSP_MORE  = 3'd5,
        RSP_NONE  = 3'd6,
        RSP_EMPTY = 3'd7
    } rsp_code_e;

    localparam int unsigned RSP_W = 3;

endpackage

// File: rtl/psp_ring.sv
module psp_ring #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_en,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    occ;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= din;
    end

    assign head  = mem[rd_ptr];
    assign full  = (occ == FULL_CNT);
    assign empty = (occ == '0);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_en);

endmodule

// File: rtl/psp_uframe.sv
module psp_uframe #(
    parameter int unsigned UF_PER_FRAME = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            uf_tick,
    output logic [$clog2(UF_PER_FRAME)-1:0] uf_num,
    output logic                            frame_start
);
    localparam int unsigned UW = $clog2(UF_PER_FRAME);
    localparam logic [UW-1:0] LAST_UF = UW'(UF_PER_FRAME - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_num      <= '0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            if (uf_tick) begin
                if (uf_num == LAST_UF) begin
                    uf_num      <= '0;
                    frame_start <= 1'b1;
                end else begin
                    uf_num <= uf_num + 1'b1;
                end
            end
        end
    end

    // R9
    frame_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (uf_num == '0));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

endmodule

// File: rtl/psp_cs_resp.sv
module psp_cs_resp
    import psp_pkg::*;
#(
    parameter int unsigned EP_W   = 11,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_valid,
    input  logic [EP_W-1:0]   cs_ep,
    input  logic              head_vld,
    input  logic [EP_W-1:0]   head_ep,
    input  logic [RSP_W-1:0]  head_status,
    input  logic [DATA_W-1:0] head_data,
    output logic              pop,
    output logic              resp_valid,
    output logic [RSP_W-1:0]  resp_status,
    output logic [DATA_W-1:0] resp_data,
    output logic              udr
);
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_HIT   = 2'd1,
        CS_MISS  = 2'd2,
        CS_UNDER = 2'd3
    } cs_state_e;

    cs_state_e         state_q, state_d;
    logic [RSP_W-1:0]  hold_status;
    logic [DATA_W-1:0] hold_data;
    logic              tag_match;

    assign tag_match = (cs_ep == head_ep);

    always_comb begin
        state_d = CS_IDLE;
        if (cs_valid) begin
            if (!head_vld)      state_d = CS_UNDER;
            else if (tag_match) state_d = CS_HIT;
            else                state_d = CS_MISS;
        end
    end

    assign pop = cs_valid && head_vld && tag_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CS_IDLE;
            hold_status <= '0;
            hold_data   <= '0;
        end else begin
            state_q <= state_d;
            if (pop) begin
                hold_status <= head_status;
                hold_data   <= head_data;
            end
        end
    end

    always_comb begin
        resp_valid  = 1'b0;
        resp_status = RSP_NONE;
        resp_data   = '0;
        udr         = 1'b0;
        unique case (state_q)
            CS_IDLE: ;
            CS_HIT: begin
                resp_valid  = 1'b1;
                resp_status = hold_status;
                resp_data   = hold_data;
            end
            CS_MISS: begin
                resp_valid  = 1'b1;
                resp_status = RSP_NONE;
            end
            CS_UNDER: begin
                resp_valid  = 1'b1;
                resp_status = RSP_EMPTY;
                udr         = 1'b1;
            end
            default: ;
        endcase
    end

    // R7
    underrun_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_valid && !head_vld) |=> (udr && resp_status == RSP_EMPTY));

    // R5
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_valid |=> resp_valid);

endmodule

// File: rtl/periodic_split_pipe.sv
module periodic_split_pipe
    import psp_pkg::*;
#(
    parameter int unsigned EP_W         = 11,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned SS_DEPTH     = 4,
    parameter int unsigned CS_DEPTH     = 4,
    parameter int unsigned UF_PER_FRAME = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ss_valid,
    output logic                            ss_ready,
    input  logic [EP_W-1:0]                 ss_ep,
    input  logic [DATA_W-1:0]               ss_data,
    output logic                            ss_ovr,
    output logic                            dn_valid,
    input  logic                            dn_ready,
    output logic [EP_W-1:0]                 dn_ep,
    output logic [DATA_W-1:0]               dn_data,
    input  logic                            res_valid,
    output logic                            res_ready,
    input  logic [EP_W-1:0]                 res_ep,
    input  logic [2:0]                      res_status,
    input  logic [DATA_W-1:0]               res_data,
    input  logic                            rx_active,
    input  logic [EP_W-1:0]                 rx_ep,
    input  logic                            uf_tick,
    output logic [$clog2(UF_PER_FRAME)-1:0] uf_num,
    output logic                            frame_start,
    input  logic                            cs_valid,
    output logic                            cs_ready,
    input  logic [EP_W-1:0]                 cs_ep,
    output logic                            cs_resp_valid,
    output logic [2:0]                      cs_resp_status,
    output logic [DATA_W-1:0]               cs_resp_data,
    output logic                            cs_udr
);
    localparam int unsigned SS_W = EP_W + DATA_W;
    localparam int unsigned CS_W = EP_W + RSP_W + DATA_W;

    // ---------------- start-split queue ----------------
    logic            ss_full, ss_empty, ss_wr, ss_rd;
    logic [SS_W-1:0] ss_head;

    assign ss_ready = !ss_full;
    assign ss_wr    = ss_valid && !ss_full;
    assign ss_ovr   = ss_valid && ss_full;
    assign dn_valid = !ss_empty;
    assign ss_rd    = dn_valid && dn_ready;
    assign {dn_ep, dn_data} = ss_head;

    psp_ring #(.WIDTH(SS_W), .DEPTH(SS_DEPTH)) u_ss_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ss_wr),
        .din   ({ss_ep, ss_data}),
        .rd_en (ss_rd),
        .head  (ss_head),
        .full  (ss_full),
        .empty (ss_empty)
    );

    // ---------------- complete-split queue ----------------
    logic              cs_full, cs_empty, cs_wr, cs_pop, capture;
    logic [CS_W-1:0]   cs_din, cs_head;
    logic [EP_W-1:0]   head_ep;
    logic [RSP_W-1:0]  head_status;
    logic [DATA_W-1:0] head_data;

    assign capture   = uf_tick && rx_active && !cs_full;
    assign res_ready = !cs_full && !capture;
    assign cs_wr     = capture || (res_valid && res_ready);
    assign cs_din    = capture ? {rx_ep, RSP_MORE, {DATA_W{1'b0}}}
                               : {res_ep, res_status, res_data};
    assign {head_ep, head_status, head_data} = cs_head;

    psp_ring #(.WIDTH(CS_W), .DEPTH(CS_DEPTH)) u_cs_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cs_wr),
        .din   (cs_din),
        .rd_en (cs_pop),
        .head  (cs_head),
        .full  (cs_full),
        .empty (cs_empty)
    );

    // ---------------- complete-split lookup ----------------
    assign cs_ready = 1'b1;

    psp_cs_resp #(.EP_W(EP_W), .DATA_W(DATA_W)) u_cs_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_valid    (cs_valid),
        .cs_ep       (cs_ep),
        .head_vld    (!cs_empty),
        .head_ep     (head_ep),
        .head_status (head_status),
        .head_data   (head_data),
        .pop         (cs_pop),
        .resp_valid  (cs_resp_valid),
        .resp_status (cs_resp_status),
        .resp_data   (cs_resp_data),
        .udr         (cs_udr)
    );

    // ---------------- microframe timer ----------------
    psp_uframe #(.UF_PER_FRAME(UF_PER_FRAME)) u_uframe (
        .clk         (clk),
        .rst_n       (rst_n),
        .uf_tick     (uf_tick),
        .uf_num      (uf_num),
        .frame_start (frame_start)
    );

    // R6
    miss_keeps_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_valid && !cs_empty && cs_ep != head_ep) |-> !cs_pop);

    // R5
    hit_pops_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_valid && !cs_empty && cs_ep == head_ep) |-> cs_pop);

    // R8
    capture_blocks_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_tick && rx_active && !cs_full) |-> (!res_ready && cs_wr));

    // R3
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_ovr |-> !ss_ready);

endmodule

// File: tb/periodic_split_pipe_tb.sv
module periodic_split_pipe_tb;
    localparam int EP_W = 11;
    localparam int DW   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ss_valid = 0, dn_ready = 0, res_valid = 0, rx_active = 0;
    logic          uf_tick = 0, cs_valid = 0;
    logic [EP_W-1:0] ss_ep = '0, res_ep = '0, rx_ep = '0, cs_ep = '0;
    logic [DW-1:0] ss_data = '0, res_data = '0;
    logic [2:0]    res_status = '0;
    logic          ss_ready, ss_ovr, dn_valid, res_ready, frame_start;
    logic          cs_ready, cs_resp_valid, cs_udr;
    logic [EP_W-1:0] dn_ep;
    logic [DW-1:0] dn_data, cs_resp_data;
    logic [2:0]    cs_resp_status, uf_num;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;
    logic [EP_W+DW-1:0] exp_ss[$];
    logic [2+DW:0]      exp_cs[$];

    always #10 clk = ~clk;

    periodic_split_pipe u_dut (
        .clk(clk), .rst_n(rst_n),
        .ss_valid(ss_valid), .ss_ready(ss_ready), .ss_ep(ss_ep), .ss_data(ss_data),
        .ss_ovr(ss_ovr),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_ep(dn_ep), .dn_data(dn_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_ep(res_ep),
        .res_status(res_status), .res_data(res_data),
        .rx_active(rx_active), .rx_ep(rx_ep),
        .uf_tick(uf_tick), .uf_num(uf_num), .frame_start(frame_start),
        .cs_valid(cs_valid), .cs_ready(cs_ready), .cs_ep(cs_ep),
        .cs_resp_valid(cs_resp_valid), .cs_resp_status(cs_resp_status),
        .cs_resp_data(cs_resp_data), .cs_udr(cs_udr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // driver: offer one start-split record for one cycle
    task automatic ss_push(input logic [EP_W-1:0] ep, input logic [DW-1:0] d,
                           input bit expect_full);
        ss_valid = 1; ss_ep = ep; ss_data = d;
        @(negedge clk);
        if (expect_full) begin
            chk(!ss_ready, "R3", "ss_ready when full", ss_ready, 0);
            chk(ss_ovr, "R3", "ss_ovr when full", ss_ovr, 1);
        end
        if (ss_ready) exp_ss.push_back({ep, d});
        step();
        ss_valid = 0;
    endtask

    task automatic res_put(input logic [EP_W-1:0] ep, input logic [2:0] st,
                           input logic [DW-1:0] d, input string req);
        res_valid = 1; res_ep = ep; res_status = st; res_data = d;
        @(negedge clk);
        chk(res_ready, req, "res_ready", res_ready, 1);
        step();
        res_valid = 0;
    endtask

    // driver: issue a lookup and push the expected response to the scoreboard
    task automatic cs_ask(input logic [EP_W-1:0] ep, input logic [2:0] st,
                          input logic [DW-1:0] d);
        cs_valid = 1; cs_ep = ep;
        exp_cs.push_back({st, d});
        step();
        cs_valid = 0;
        step();
    endtask

    task automatic tick();
        uf_tick = 1;
        step();
        uf_tick = 0;
        ticks++;
    endtask

    // monitor: downstream record order (R2)
    always @(negedge clk) begin
        if (rst_n && dn_valid && dn_ready) begin
            if (exp_ss.size() == 0) begin
                chk(0, "R2", "unexpected downstream record", {dn_ep, dn_data}, 0);
            end else begin
                logic [EP_W+DW-1:0] e;
                e = exp_ss.pop_front();
                chk({dn_ep, dn_data} == e, "R2", "downstream record", {dn_ep, dn_data}, e);
            end
        end
    end

    // monitor: complete-split responses (R5 R6 R7)
    always @(negedge clk) begin
        if (rst_n && cs_resp_valid) begin
            if (exp_cs.size() == 0) begin
                chk(0, "R5", "unexpected response", cs_resp_status, 0);
            end else begin
                logic [2+DW:0] e;
                e = exp_cs.pop_front();
                chk({cs_resp_status, cs_resp_data} == e, "R5_R6_R7", "response",
                    {cs_resp_status, cs_resp_data}, e);
                chk(cs_udr == (e[2+DW:DW] == 3'd7), "R7", "cs_udr", cs_udr,
                    (e[2+DW:DW] == 3'd7));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "WATCHDOG", "run timed out", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ss_ready, "R1", "ss_ready", ss_ready, 1);
        chk(!dn_valid, "R1", "dn_valid", dn_valid, 0);
        chk(res_ready, "R1", "res_ready", res_ready, 1);
        chk(uf_num == 0, "R1", "uf_num", uf_num, 0);
        chk(!cs_resp_valid && !cs_udr, "R1", "cs response", cs_resp_valid, 0);
        chk(!frame_start, "R1", "frame_start", frame_start, 0);
        step();

        // R2: order preserved
        ss_push(11'h101, 32'hA0A0_0001, 0);
        ss_push(11'h102, 32'hA0A0_0002, 0);
        ss_push(11'h103, 32'hA0A0_0003, 0);
        dn_ready = 1;
        repeat (5) step();
        chk(exp_ss.size() == 0, "R2", "all records drained", exp_ss.size(), 0);
        dn_ready = 0;

        // R3: fill then overrun; R10: results still accepted
        for (int i = 0; i < 4; i++) ss_push(11'(9'h40 + i), 32'hB000_0000 + i, 0);
        ss_push(11'h7FF, 32'hDEAD_BEEF, 1);
        res_put(11'h011, 3'd0, 32'h1111_2222, "R10");
        dn_ready = 1;
        repeat (6) step();
        chk(exp_ss.size() == 0, "R3", "stored records drained", exp_ss.size(), 0);
        chk(!dn_valid, "R3", "overrun record not stored", dn_valid, 0);
        dn_ready = 0;

        // R4 R5 R6 R7: result queue and lookups
        res_put(11'h022, 3'd4, 32'h0000_CAFE, "R4");
        cs_ask(11'h011, 3'd0, 32'h1111_2222);   // R5 hit
        cs_ask(11'h033, 3'd6, 32'h0);           // R6 miss
        cs_ask(11'h022, 3'd4, 32'h0000_CAFE);   // R6 head kept, R4 last data
        cs_ask(11'h022, 3'd7, 32'h0);           // R7 underrun

        // R8: microframe boundary while receiving
        rx_active = 1; rx_ep = 11'h055; uf_tick = 1;
        res_valid = 1; res_ep = 11'h066; res_status = 3'd1; res_data = 32'h7;
        @(negedge clk);
        chk(!res_ready, "R8", "res_ready during capture", res_ready, 0);
        step();
        ticks++;
        rx_active = 0; uf_tick = 0; res_valid = 0;
        cs_ask(11'h055, 3'd5, 32'h0);
        cs_ask(11'h066, 3'd7, 32'h0);           // R8 blocked result not stored

        // R9: microframe counter and frame pulse
        @(negedge clk);
        chk(uf_num == 3'(ticks), "R9", "uf_num after capture tick", uf_num, ticks);
        while (ticks < 7) tick();
        @(negedge clk);
        chk(uf_num == 3'd7, "R9", "uf_num before wrap", uf_num, 7);
        chk(!frame_start, "R9", "no pulse before wrap", frame_start, 0);
        tick();
        @(negedge clk);
        chk(uf_num == 3'd0, "R9", "uf_num wrap", uf_num, 0);
        chk(frame_start, "R9", "frame_start pulse", frame_start, 1);
        step();
        @(negedge clk);
        chk(!frame_start, "R9", "frame_start one cycle", frame_start, 0);

        repeat (3) step();
        chk(exp_cs.size() == 0, "R5", "all responses seen", exp_cs.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule